// File: doc/BRIEF.md
# Negative Slope Peak Detector

This block decides when a nickel-based battery pack is full by watching for the small voltage drop that follows the charge peak. A phase counter, advanced by a divided system tick, drives an active-low sense gate. The sense gate pauses the external charger once per sampling period. At the start of each gate interval, a settle window clears the sample counter. A measurement window then follows. During the measurement window, single-cycle pulses from an external voltage-to-frequency converter are counted. The converter itself is modelled as the digital pulse input `vfc_pulse`.

When a measurement window closes, the count is compared against a ratcheting peak. A larger count becomes the new peak. A count at least `DROP_MARGIN` below the peak is a drop event. Two drop events in successive samples set the full-charge flag, but only once a holdoff interval has elapsed since the last reset. A drop that recovers before the holdoff ends does not terminate the charge. A separate start delay masks samples taken just after reset. The surrounding mode logic restarts the detector through the synchronous active-low reset.

Top module: `neg_slope_detector`

## Requirements
- R1: `sense_gate_n` is 0 while the phase counter is below `GATE_TICKS` and 1 for the rest of each `PERIOD_TICKS`-tick period. The phase counter starts at 0 after reset and advances only on cycles with `tick` = 1.
- R2: `preset_win` is 1 for the first `PRESET_TICKS` phases of the period. `convert_win` is 1 for the `CONVERT_TICKS` phases that follow. The two windows never overlap, and both lie inside the gate-low interval.
- R3: A `vfc_pulse` high on a clock cycle adds one to the sample count only while `convert_win` is 1. The sample count is cleared throughout `preset_win`.
- R4: The sample count saturates at 2^`CNT_W`-1, so more pulses in one window leave it at that value.
- R5: A sample is evaluated on the tick that ends the convert window, and that cycle's pulse is included. A sample larger than `peak_count` replaces it and sets `drop_events` to 0.
- R6: A sample at least `DROP_MARGIN` below `peak_count` increments `drop_events`, which saturates at 2. Any other sample sets `drop_events` to 0 and leaves the peak unchanged.
- R7: Samples evaluated before `START_TICKS` ticks have elapsed since reset change nothing. `full_charge` rises one cycle after `drop_events` = 2 and the holdoff (`HOLDOFF_TICKS`, or four times that when `LONG_HOLDOFF` = 1) have both been reached.
- R8: A drop that a new peak clears before the holdoff ends leaves `full_charge` at 0. Once set, `full_charge` stays 1 until reset.
- R9: With `rst_n` = 0 at a clock edge, the phase, sample count, peak, drop events, holdoff counter and `full_charge` all return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low restart from the mode logic |
| tick | input | 1 | Divided time-base enable, one cycle wide |
| vfc_pulse | input | 1 | One pulse per converter output event |
| sense_gate_n | output | 1 | Active-low charger pause |
| preset_win | output | 1 | Settle window, sample count cleared |
| convert_win | output | 1 | Measurement window, pulses counted |
| peak_count | output | CNT_W | Ratcheted peak sample |
| drop_events | output | 2 | Consecutive below-peak samples, saturating at 2 |
| full_charge | output | 1 | Latched end-of-charge flag |

## Verification
A phase counter that slips shows up first. `sense_gate_n` and the two windows move against the reference within one tick of the error. The next peak or event value then differs at the end of that period. A wrong sample count or comparison edge shows at `peak_count` or `drop_events` on the cycle after the window closes. A holdoff counter that runs early or late moves the rise of `full_charge`, which the bench catches on the very cycle it occurs. The stimulus covers a stored-cell drop that recovers during holdoff, a sample equal to the peak, saturation, a genuine termination after holdoff, and a reset in mid-run.

// File: rtl/neg_slope_pkg.sv
package neg_slope_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_ONE  = 2'd1,
        EV_TWO  = 2'd2
    } drop_ev_e;

    typedef enum logic [1:0] {
        CMP_RISE,
        CMP_DROP,
        CMP_FLAT
    } cmp_res_e;

    function automatic drop_ev_e ev_step(input drop_ev_e cur);
        return (cur == EV_NONE) ? EV_ONE : EV_TWO;
    endfunction

endpackage

// File: rtl/nsd_sequencer.sv
module nsd_sequencer #(
    parameter int PERIOD_TICKS  = 1380,
    parameter int GATE_TICKS    = 33,
    parameter int PRESET_TICKS  = 11,
    parameter int CONVERT_TICKS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic gate_n,
    output logic pre_win,
    output logic cv_win,
    output logic eval
);
    localparam int PH_W = $clog2(PERIOD_TICKS);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD_TICKS - 1);
    localparam logic [PH_W-1:0] PH_GATE  = PH_W'(GATE_TICKS);
    localparam logic [PH_W-1:0] PH_PRE   = PH_W'(PRESET_TICKS);
    localparam logic [PH_W-1:0] PH_CVEND = PH_W'(PRESET_TICKS + CONVERT_TICKS);
    localparam logic [PH_W-1:0] PH_CVLST = PH_W'(PRESET_TICKS + CONVERT_TICKS - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.ph = (s_q.ph == PH_LAST) ? '0 : s_q.ph + 1'b1;
        end
        if (!rst_n) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign gate_n  = !(s_q.ph < PH_GATE);
    assign pre_win = (s_q.ph < PH_PRE);
    assign cv_win  = (s_q.ph >= PH_PRE) && (s_q.ph < PH_CVEND);
    assign eval    = cv_win && tick && (s_q.ph == PH_CVLST);

    AST_WIN_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_win && cv_win)); // R2
    AST_WIN_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_win || cv_win) |-> !gate_n); // R1
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !tick |=> $stable(gate_n) && $stable(pre_win) && $stable(cv_win)); // R1

endmodule

// File: rtl/nsd_ratchet.sv
module nsd_ratchet
    import neg_slope_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int DROP_MARGIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_win,
    input  logic             cv_win,
    input  logic             eval,
    input  logic             armed,
    input  logic             pulse,
    output logic [CNT_W-1:0] peak,
    output drop_ev_e         events
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W:0]   MARGIN  = (CNT_W+1)'(DROP_MARGIN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] peak;
        drop_ev_e         ev;
    } rat_t;

    rat_t r_d, r_q;
    logic [CNT_W-1:0] sample;
    cmp_res_e         cmp;

    always_comb begin
        sample = r_q.cnt;
        if (cv_win && pulse && (r_q.cnt != CNT_MAX)) begin
            sample = r_q.cnt + 1'b1;
        end
    end

    always_comb begin
        if (sample > r_q.peak) begin
            cmp = CMP_RISE;
        end else if (({1'b0, sample} + MARGIN) <= {1'b0, r_q.peak}) begin
            cmp = CMP_DROP;
        end else begin
            cmp = CMP_FLAT;
        end
    end

    always_comb begin
        r_d = r_q;
        if (pre_win) begin
            r_d.cnt = '0;
        end else if (cv_win) begin
            r_d.cnt = sample;
        end
        if (eval && armed) begin
            unique case (cmp)
                CMP_RISE: begin
                    r_d.peak = sample;
                    r_d.ev   = EV_NONE;
                end
                CMP_DROP: r_d.ev = ev_step(r_q.ev);
                default:  r_d.ev = EV_NONE;
            endcase
        end
        if (!rst_n) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign peak   = r_q.peak;
    assign events = r_q.ev;

    AST_PEAK_RATCHET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> peak >= $past(peak)); // R5
    AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !cv_win && !pre_win |=> $stable(r_q.cnt)); // R3
    AST_EVENTS_ONLY_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !(eval && armed) |=> $stable(events) && $stable(peak)); // R6
    AST_EVENTS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        events != 2'd3); // R6

endmodule

// File: rtl/nsd_holdoff.sv
module nsd_holdoff #(
    parameter int START_TICKS   = 60,
    parameter int HOLDOFF_TICKS = 177000,
    parameter bit LONG_HOLDOFF  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic armed,
    output logic done
);
    localparam int HOLD_LIMIT = LONG_HOLDOFF ? 4 * HOLDOFF_TICKS : HOLDOFF_TICKS;
    localparam int HC_W       = $clog2(HOLD_LIMIT + 1);
    localparam logic [HC_W-1:0] HC_START = HC_W'(START_TICKS);
    localparam logic [HC_W-1:0] HC_END   = HC_W'(HOLD_LIMIT);

    typedef struct packed {
        logic [HC_W-1:0] hc;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (tick && (h_q.hc != HC_END)) begin
            h_d.hc = h_q.hc + 1'b1;
        end
        if (!rst_n) begin
            h_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        h_q <= h_d;
    end

    assign armed = (h_q.hc >= HC_START);
    assign done  = (h_q.hc == HC_END);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && done |=> done); // R7
    AST_DONE_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> armed); // R7

endmodule

// File: rtl/neg_slope_detector.sv
module neg_slope_detector
    import neg_slope_pkg::*;
#(
    parameter int PERIOD_TICKS  = 1380,
    parameter int GATE_TICKS    = 33,
    parameter int PRESET_TICKS  = 11,
    parameter int CONVERT_TICKS = 22,
    parameter int CNT_W         = 10,
    parameter int DROP_MARGIN   = 2,
    parameter int START_TICKS   = 60,
    parameter int HOLDOFF_TICKS = 177000,
    parameter bit LONG_HOLDOFF  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             vfc_pulse,
    output logic             sense_gate_n,
    output logic             preset_win,
    output logic             convert_win,
    output logic [CNT_W-1:0] peak_count,
    output logic [1:0]       drop_events,
    output logic             full_charge
);
    typedef struct packed {
        logic full;
    } top_t;

    logic     eval, armed, done;
    drop_ev_e events;
    top_t     t_d, t_q;

    nsd_sequencer #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .GATE_TICKS   (GATE_TICKS),
        .PRESET_TICKS (PRESET_TICKS),
        .CONVERT_TICKS(CONVERT_TICKS)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .gate_n (sense_gate_n),
        .pre_win(preset_win),
        .cv_win (convert_win),
        .eval   (eval)
    );

    nsd_ratchet #(
        .CNT_W      (CNT_W),
        .DROP_MARGIN(DROP_MARGIN)
    ) u_rat (
        .clk    (clk),
        .rst_n  (rst_n),
        .pre_win(preset_win),
        .cv_win (convert_win),
        .eval   (eval),
        .armed  (armed),
        .pulse  (vfc_pulse),
        .peak   (peak_count),
        .events (events)
    );

    nsd_holdoff #(
        .START_TICKS  (START_TICKS),
        .HOLDOFF_TICKS(HOLDOFF_TICKS),
        .LONG_HOLDOFF (LONG_HOLDOFF)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .armed (armed),
        .done  (done)
    );

    always_comb begin
        t_d = t_q;
        if (done && (events == EV_TWO)) begin
            t_d.full = 1'b1;
        end
        if (!rst_n) begin
            t_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign drop_events = events;
    assign full_charge = t_q.full;

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && full_charge |=> full_charge); // R8
    AST_FULL_AFTER_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        full_charge |-> done); // R7
    AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !full_charge && !(done && events == EV_TWO) |=> !full_charge); // R7

endmodule

// File: tb/neg_slope_detector_tb.sv
module neg_slope_detector_tb;
    localparam int PER   = 40;
    localparam int GATE  = 16;
    localparam int PRE   = 4;
    localparam int CV    = 10;
    localparam int CW    = 4;
    localparam int MARG  = 2;
    localparam int START = 20;
    localparam int HOLD  = 300;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic vfc_pulse = 1'b0;
    logic sense_gate_n, preset_win, convert_win, full_charge;
    logic [CW-1:0] peak_count;
    logic [1:0] drop_events;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int m_ph = 0, m_cnt = 0, m_peak = 0, m_ev = 0, m_hc = 0, m_ticks = 0;
    bit m_full = 0;

    always #4 clk = ~clk;

    neg_slope_detector #(
        .PERIOD_TICKS(PER), .GATE_TICKS(GATE), .PRESET_TICKS(PRE),
        .CONVERT_TICKS(CV), .CNT_W(CW), .DROP_MARGIN(MARG),
        .START_TICKS(START), .HOLDOFF_TICKS(HOLD), .LONG_HOLDOFF(1'b0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vfc_pulse(vfc_pulse),
        .sense_gate_n(sense_gate_n), .preset_win(preset_win),
        .convert_win(convert_win), .peak_count(peak_count),
        .drop_events(drop_events), .full_charge(full_charge)
    );

    function automatic bit m_pre(); return m_ph < PRE; endfunction
    function automatic bit m_cv();  return (m_ph >= PRE) && (m_ph < PRE + CV); endfunction

    always @(posedge clk) begin
        int samp;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_peak = 0; m_ev = 0; m_hc = 0; m_full = 0; m_ticks = 0;
        end else begin
            samp = m_cnt + ((m_cv() && vfc_pulse) ? 1 : 0);
            if (samp > CMAX) samp = CMAX;
            if (m_hc >= HOLD && m_ev == 2) m_full = 1;
            if (tick && m_cv() && m_ph == PRE + CV - 1 && m_hc >= START) begin
                if (samp > m_peak) begin
                    m_peak = samp; m_ev = 0;
                end else if (samp + MARG <= m_peak) begin
                    m_ev = (m_ev == 0) ? 1 : 2;
                end else begin
                    m_ev = 0;
                end
            end
            if (m_pre()) m_cnt = 0;
            else if (m_cv()) m_cnt = samp;
            if (tick) begin
                m_ph = (m_ph == PER - 1) ? 0 : m_ph + 1;
                m_ticks++;
                if (m_hc < HOLD) m_hc++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 sense_gate_n", int'(sense_gate_n), int'(!(m_ph < GATE)));
        chk("R2 preset_win", int'(preset_win), int'(m_pre()));
        chk("R2 convert_win", int'(convert_win), int'(m_cv()));
        chk("R3 R5 peak_count", int'(peak_count), m_peak);
        chk("R6 drop_events", int'(drop_events), m_ev);
        chk("R8 full_charge", int'(full_charge), int'(m_full));
    endtask

    // pulse spacing per sampling period: 0 ignored, rise, rise, drop, equal,
    // drop, drop, saturating rise, drop, drop, steady
    function automatic int spacing(input int p);
        case (p)
            0: return 1;
            1: return 3;
            2: return 2;
            3: return 3;
            4: return 2;
            5: return 3;
            6: return 3;
            7: return 1;
            8: return 2;
            9: return 2;
            default: return 2;
        endcase
    endfunction

    task automatic run_to_tick(input int target);
        while (m_ticks < target) begin
            @(negedge clk);
            cyc++;
            compare_all();
            tick = (cyc % 2 == 0);
            vfc_pulse = (cyc % spacing(m_ticks / PER) == 0);
        end
        @(negedge clk);
        cyc++;
        compare_all();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset peak", int'(peak_count), 0);
        chk("R9 reset events", int'(drop_events), 0);
        chk("R9 reset full", int'(full_charge), 0);
        chk("R1 gate low at phase 0", int'(sense_gate_n), 0);
        rst_n = 1'b1;

        run_to_tick(PER);
        chk("R7 start delay masks first sample", int'(peak_count), 0);
        run_to_tick(7 * PER);
        chk("R8 no termination before holdoff", int'(full_charge), 0);
        run_to_tick(8 * PER);
        chk("R4 saturated peak", int'(peak_count), CMAX);
        chk("R8 recovery during holdoff", int'(full_charge), 0);
        run_to_tick(10 * PER);
        chk("R7 terminated after holdoff", int'(full_charge), 1);
        chk("R6 two drop events", int'(drop_events), 2);
        run_to_tick(11 * PER);
        chk("R8 flag sticky", int'(full_charge), 1);

        // mid-run restart
        @(negedge clk);
        rst_n = 1'b0;
        tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 restart peak", int'(peak_count), 0);
        chk("R9 restart events", int'(drop_events), 0);
        chk("R9 restart full", int'(full_charge), 0);
        chk("R9 restart gate", int'(sense_gate_n), 0);
        run_to_tick(3 * PER);
        chk("R3 counting resumes", int'(peak_count != 0), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule